// File: doc/BRIEF.md
# Predictive Variable-Latency Hybrid Adder

This block adds two unsigned operands and a carry-in. It is built from carry-skip stages. Each stage ripples its bits with a zero carry-in, then corrects the result through a half-adder increment chain once the real stage carry arrives. A fixed slice of the operand, called the nucleus, is a parallel-prefix section with a logarithmic generate/propagate network instead of a ripple stage. The group propagate of that slice acts as a run-time predictor.

When the group propagate is low, the carry leaving the nucleus is its own group generate. The upper stages then do not depend on the lower ones, and the result is delivered one cycle after the start. When the group propagate is high, the lower carry has to travel through the nucleus into the upper stages. That long path is given a second cycle. During the second cycle the block reports busy and refuses new starts. A flag tells the consumer which latency the current addition used. The result register acts as the pipeline register that models both latencies. The sum itself is always exact.

Top module: `vla_adder`

## Requirements
- R1: On an accepted start (start_i high while busy_o is low), {cout_o, sum_o} is loaded with a_i + b_i + cin_i taken modulo 2^(WIDTH+1). It is visible from the cycle after the start and held until the next accepted start.
- R2: The predictor is the AND of (a_i ^ b_i) over bits NUC_LSB to NUC_LSB+NUC_W-1. On an accepted start, two_cyc_o is loaded with the predictor value: 1 means two cycles, 0 means one cycle.
- R3: With the predictor at 0, valid_o is high and busy_o is low in the cycle after the accepted start.
- R4: With the predictor at 1, busy_o is high and valid_o is low in the cycle after the accepted start. In the cycle after that, valid_o is high and busy_o is low.
- R5: A start_i raised while busy_o is high is ignored. The pending result, two_cyc_o and the completion timing are unchanged, and no extra valid_o pulse follows.
- R6: valid_o is high for exactly one cycle per accepted start. It stays low when no start has been accepted.
- R7: While reset is active, and after it is released until the first accepted start, valid_o, busy_o, two_cyc_o, cout_o and sum_o are all 0.
- R8: A start raised in the same cycle that valid_o is high is accepted, so one-cycle additions can follow one another on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Request a new addition |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry-in |
| sum_o | output | WIDTH | Registered sum |
| cout_o | output | 1 | Registered carry-out |
| valid_o | output | 1 | Result ready, one-cycle pulse |
| busy_o | output | 1 | Second cycle of a long-path addition; starts are refused |
| two_cyc_o | output | 1 | Latency flag of the current result: 1 for two cycles |

## Verification
The bench builds the adder with WIDTH=8, NUC_LSB=2, NUC_W=4 and BLK_W=2. That gives one two-bit skip stage below the nucleus, a four-bit prefix nucleus, and one two-bit skip stage above it. At this size every pair of operands can be applied, with the carry-in taken from the operand parity. The sweep therefore reaches every nucleus propagate pattern, every increment overflow in both skip stages, and every case where the lower carry must cross the nucleus. Each two-cycle addition also gets a spurious start during its busy cycle. The sweep runs back to back, so starts accepted in the valid cycle are exercised throughout.

// File: rtl/vla_pkg.sv
package vla_pkg;

  // generate / propagate pair used by the prefix network
  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

  // combine a more significant span (hi) with the adjacent lower span (lo)
  function automatic gp_t gp_merge(gp_t hi, gp_t lo);
    gp_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

endpackage

// File: rtl/vla_skip_stage.sv
// Carry-skip stage: ripple with zero carry-in, then a half-adder increment
// chain driven by the real stage carry. Carry-out is the ripple carry or
// the overflow of the increment.
module vla_skip_stage #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] s_o,
  output logic         c_o
);

  logic [W:0]   rc;
  logic [W-1:0] isum;
  logic [W:0]   ic;

  assign rc[0] = 1'b0;
  assign ic[0] = c_i;

  for (genvar j = 0; j < W; j++) begin : g_bit
    logic x;
    assign x = a_i[j] ^ b_i[j];
    // full adder as two muxes selected by the ripple carry
    assign isum[j]  = rc[j] ? ~x : x;
    assign rc[j+1]  = rc[j] ? (a_i[j] | b_i[j]) : (a_i[j] & b_i[j]);
    // half adder as two muxes selected by the increment carry
    assign s_o[j]   = ic[j] ? ~isum[j] : isum[j];
    assign ic[j+1]  = ic[j] ? isum[j] : 1'b0;
  end

  assign c_o = rc[W] | ic[W];

endmodule

// File: rtl/vla_ks_nucleus.sv
// Prefix nucleus: bitwise pre-processing, log-depth prefix network,
// carries formed from the incoming carry, then sum post-processing.
module vla_ks_nucleus
  import vla_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] s_o,
  output logic         grp_g_o,
  output logic         grp_p_o
);

  localparam int L = (W > 1) ? $clog2(W) : 0;

  gp_t        lv [0:L][0:W-1];
  logic [W-1:0] c;

  for (genvar i = 0; i < W; i++) begin : g_pre
    assign lv[0][i].g = a_i[i] & b_i[i];
    assign lv[0][i].p = a_i[i] ^ b_i[i];
  end

  for (genvar k = 0; k < L; k++) begin : g_lvl
    for (genvar i = 0; i < W; i++) begin : g_node
      if (i >= (1 << k)) begin : g_merge
        assign lv[k+1][i] = gp_merge(lv[k][i], lv[k][i-(1<<k)]);
      end else begin : g_pass
        assign lv[k+1][i] = lv[k][i];
      end
    end
  end

  assign c[0] = c_i;
  for (genvar i = 1; i < W; i++) begin : g_carry
    assign c[i] = lv[L][i-1].g | (lv[L][i-1].p & c_i);
  end

  for (genvar i = 0; i < W; i++) begin : g_post
    assign s_o[i] = lv[0][i].p ^ c[i];
  end

  assign grp_g_o = lv[L][W-1].g;
  assign grp_p_o = lv[L][W-1].p;

endmodule

// File: rtl/vla_ctrl.sv
// Latency control: one cycle when the predictor is low, two when high.
module vla_ctrl (
  input  logic clk_i,
  input  logic rst_n,
  input  logic start_i,
  input  logic pred_i,
  output logic accept_o,
  output logic busy_o,
  output logic valid_o
);

  logic busy_q, busy_d;
  logic valid_q, valid_d;

  always_comb begin
    accept_o = start_i & ~busy_q;
    busy_d   = accept_o & pred_i;
    valid_d  = (accept_o & ~pred_i) | busy_q;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      valid_q <= valid_d;
    end
  end

  assign busy_o  = busy_q;
  assign valid_o = valid_q;

endmodule

// File: rtl/vla_adder.sv
module vla_adder #(
  parameter int WIDTH   = 32,
  parameter int NUC_LSB = 12,
  parameter int NUC_W   = 4,
  parameter int BLK_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             valid_o,
  output logic             busy_o,
  output logic             two_cyc_o
);

  localparam int NLO    = NUC_LSB / BLK_W;
  localparam int HI_LSB = NUC_LSB + NUC_W;
  localparam int NHI    = (WIDTH - HI_LSB) / BLK_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe <= 2'b00;
    else         rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n = rst_pipe[1];

  // datapath
  logic [WIDTH-1:0] sum_c;
  logic [NLO:0]     lo_c;
  logic [NHI:0]     hi_c;
  logic             nuc_gg, nuc_gp, nuc_co;

  assign lo_c[0] = cin_i;

  for (genvar i = 0; i < NLO; i++) begin : g_lo
    vla_skip_stage #(.W(BLK_W)) u_stg (
      .a_i (a_i[i*BLK_W +: BLK_W]),
      .b_i (b_i[i*BLK_W +: BLK_W]),
      .c_i (lo_c[i]),
      .s_o (sum_c[i*BLK_W +: BLK_W]),
      .c_o (lo_c[i+1])
    );
  end

  vla_ks_nucleus #(.W(NUC_W)) u_nuc (
    .a_i     (a_i[NUC_LSB +: NUC_W]),
    .b_i     (b_i[NUC_LSB +: NUC_W]),
    .c_i     (lo_c[NLO]),
    .s_o     (sum_c[NUC_LSB +: NUC_W]),
    .grp_g_o (nuc_gg),
    .grp_p_o (nuc_gp)
  );

  // skip: the lower carry passes only when the whole nucleus propagates
  assign nuc_co  = nuc_gp ? lo_c[NLO] : nuc_gg;
  assign hi_c[0] = nuc_co;

  for (genvar i = 0; i < NHI; i++) begin : g_hi
    vla_skip_stage #(.W(BLK_W)) u_stg (
      .a_i (a_i[HI_LSB + i*BLK_W +: BLK_W]),
      .b_i (b_i[HI_LSB + i*BLK_W +: BLK_W]),
      .c_i (hi_c[i]),
      .s_o (sum_c[HI_LSB + i*BLK_W +: BLK_W]),
      .c_o (hi_c[i+1])
    );
  end

  // control
  logic accept;

  vla_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .pred_i   (nuc_gp),
    .accept_o (accept),
    .busy_o   (busy_o),
    .valid_o  (valid_o)
  );

  // result register
  logic [WIDTH-1:0] sum_q, sum_d;
  logic             cout_q, cout_d;
  logic             two_q, two_d;

  always_comb begin
    sum_d  = sum_q;
    cout_d = cout_q;
    two_d  = two_q;
    if (accept) begin
      sum_d  = sum_c;
      cout_d = hi_c[NHI];
      two_d  = nuc_gp;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      sum_q  <= '0;
      cout_q <= 1'b0;
      two_q  <= 1'b0;
    end else begin
      sum_q  <= sum_d;
      cout_q <= cout_d;
      two_q  <= two_d;
    end
  end

  assign sum_o     = sum_q;
  assign cout_o    = cout_q;
  assign two_cyc_o = two_q;

endmodule

// File: rtl/vla_adder_chk.sv
module vla_adder_chk #(
  parameter int WIDTH   = 32,
  parameter int NUC_LSB = 12,
  parameter int NUC_W   = 4
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             start_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             cin_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o,
  input logic             valid_o,
  input logic             busy_o,
  input logic             two_cyc_o
);

  logic pred_w, acc_w;
  assign pred_w = &(a_i[NUC_LSB +: NUC_W] ^ b_i[NUC_LSB +: NUC_W]);
  assign acc_w  = start_i & ~busy_o;

  AST_SUM_EXACT: assert property (@(posedge clk_i) disable iff (!rst_n)
    acc_w |=> {cout_o, sum_o} == ({1'b0, $past(a_i)} + {1'b0, $past(b_i)} + {{WIDTH{1'b0}}, $past(cin_i)})); // R1

  AST_FAST_DONE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (acc_w && !pred_w) |=> (valid_o && !busy_o && !two_cyc_o)); // R3

  AST_SLOW_WAIT: assert property (@(posedge clk_i) disable iff (!rst_n)
    (acc_w && pred_w) |=> (!valid_o && busy_o && two_cyc_o)); // R4

  AST_SLOW_DONE: assert property (@(posedge clk_i) disable iff (!rst_n)
    busy_o |=> (valid_o && !busy_o)); // R4

  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
    busy_o |=> ($stable(sum_o) && $stable(cout_o) && $stable(two_cyc_o))); // R5

  AST_VALID_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_n)
    valid_o |-> ($past(acc_w && !pred_w) || $past(busy_o))); // R6

endmodule

bind vla_adder vla_adder_chk #(
  .WIDTH   (WIDTH),
  .NUC_LSB (NUC_LSB),
  .NUC_W   (NUC_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .a_i       (a_i),
  .b_i       (b_i),
  .cin_i     (cin_i),
  .sum_o     (sum_o),
  .cout_o    (cout_o),
  .valid_o   (valid_o),
  .busy_o    (busy_o),
  .two_cyc_o (two_cyc_o)
);

// File: tb/vla_adder_test.sv
module vla_adder_test;

  localparam int W   = 8;
  localparam int NL  = 2;
  localparam int NW  = 4;
  localparam int BW  = 2;

  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic         start_i;
  logic [W-1:0] a_i, b_i;
  logic         cin_i;
  logic [W-1:0] sum_o;
  logic         cout_o, valid_o, busy_o, two_cyc_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  vla_adder #(.WIDTH(W), .NUC_LSB(NL), .NUC_W(NW), .BLK_W(BW)) uut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .cin_i     (cin_i),
    .sum_o     (sum_o),
    .cout_o    (cout_o),
    .valid_o   (valid_o),
    .busy_o    (busy_o),
    .two_cyc_o (two_cyc_o)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic bit pred_of(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] x;
    x = a ^ b;
    return &x[NL +: NW];
  endfunction

  // Called at a negedge; leaves start_i high on return so the next call is back to back (R8).
  task automatic run_vec(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
    logic [W:0] exp_r;
    bit         p;
    exp_r = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
    p     = pred_of(a, b);
    a_i = a; b_i = b; cin_i = c; start_i = 1'b1;
    @(negedge clk_i);
    if (!p) begin
      chk(valid_o === 1'b1 && busy_o === 1'b0, "R3 fast valid/busy", {valid_o, busy_o}, 2'b10);
      chk(two_cyc_o === 1'b0, "R2 flag fast", two_cyc_o, 0);
      chk({cout_o, sum_o} === exp_r, "R1 sum fast", {cout_o, sum_o}, exp_r);
    end else begin
      chk(valid_o === 1'b0 && busy_o === 1'b1, "R4 slow first cycle", {valid_o, busy_o}, 2'b01);
      chk(two_cyc_o === 1'b1, "R2 flag slow", two_cyc_o, 1);
      // spurious start during busy must be ignored (R5)
      a_i = ~a; b_i = b + 8'd1; cin_i = ~c; start_i = 1'b1;
      @(negedge clk_i);
      chk(valid_o === 1'b1 && busy_o === 1'b0, "R4 slow done", {valid_o, busy_o}, 2'b10);
      chk({cout_o, sum_o} === exp_r && two_cyc_o === 1'b1, "R5 R1 slow result kept",
          {two_cyc_o, cout_o, sum_o}, {1'b1, exp_r});
    end
  endtask

  bit done = 1'b0;

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; start_i = 1'b0; a_i = '0; b_i = '0; cin_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk({valid_o, busy_o, two_cyc_o, cout_o, sum_o} === '0, "R7 in reset",
        {valid_o, busy_o, two_cyc_o, cout_o, sum_o}, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk({valid_o, busy_o, two_cyc_o, cout_o, sum_o} === '0, "R7 after release",
        {valid_o, busy_o, two_cyc_o, cout_o, sum_o}, 0);

    // single fast then idle: valid is a pulse, result held (R6)
    run_vec(8'h01, 8'h02, 1'b0);
    start_i = 1'b0;
    @(negedge clk_i);
    chk(valid_o === 1'b0 && {cout_o, sum_o} === 9'h003, "R6 fast pulse ends",
        {valid_o, cout_o, sum_o}, 10'h003);

    // single slow then idle: no extra valid (R6, R5)
    run_vec(8'h3C, 8'h00, 1'b1);
    start_i = 1'b0;
    @(negedge clk_i);
    chk(valid_o === 1'b0 && busy_o === 1'b0, "R6 slow pulse ends", {valid_o, busy_o}, 0);
    chk({cout_o, sum_o} === 9'h03D, "R5 result after ignored start", {cout_o, sum_o}, 9'h03D);

    // full sweep of operand pairs, back to back (R1 R2 R3 R4 R5 R8)
    for (int ia = 0; ia < 256; ia++) begin
      for (int ib = 0; ib < 256; ib++) begin
        logic [W-1:0] av, bv;
        av = ia[W-1:0];
        bv = ib[W-1:0];
        run_vec(av, bv, ^(av ^ bv));
      end
    end
    start_i = 1'b0;
    @(negedge clk_i);
    chk(valid_o === 1'b0 && busy_o === 1'b0, "R6 idle after sweep", {valid_o, busy_o}, 0);

    // extremes: full overflow across all stages
    run_vec(8'hFF, 8'hFF, 1'b1);
    run_vec(8'hFF, 8'h00, 1'b1);
    start_i = 1'b0;
    @(negedge clk_i);
    chk({cout_o, sum_o} === 9'h100, "R1 full carry chain", {cout_o, sum_o}, 9'h100);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule